// File: doc/BRIEF.md
# Equal-Branch Next-PC Unit with Alignment Guard

This unit sits beside a simple in-order fetch path. Each cycle it takes the current 32-bit instruction word, the two source operand values read for it, and the low bits of the data address that the execute stage computed. From these it works out three things:

- the instruction's format class;
- the address of the next instruction, either sequential or the target of a branch-if-equal;
- whether the chosen target or the word-load address breaks the alignment rule.

The unit owns the program counter. The PC moves to the chosen target when the advance strobe is high. It keeps its value if the target is misaligned.

A parameter selects whether 16-bit compressed instructions are allowed. With them allowed, only PC bit 0 has to be zero. Without them, both low bits have to be zero. All results are registered and appear one clock after the inputs are sampled. The PC update happens on that same edge. Reset is synchronous and active high.

Top module: `pc_step_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `pc` and `next_pc` take the parameter `RESET_VEC` and every flag output goes low.
- R2: The format flags are decoded from opcode bits 6:0. Opcode 0x33 raises `fmt_r`. Opcodes 0x13, 0x03 and 0x67 raise `fmt_i`. Opcode 0x23 raises `fmt_s`. Opcode 0x63 raises `fmt_b`. Any other opcode raises no flag.
- R3: No more than one of `fmt_r`, `fmt_i`, `fmt_s`, `fmt_b` is high in any cycle.
- R4: A branch is taken when the opcode is 0x63, funct3 (bits 14:12) is 0, and `opnd_a` equals `opnd_b`. When it is taken, `next_pc` is the PC plus a sign-extended offset. The offset's bit 12 is insn[31], bit 11 is insn[7], bits 10:5 are insn[30:25], bits 4:1 are insn[11:8], and bit 0 is zero.
- R5: In every other case, `next_pc` is the PC plus 4. This includes a branch with unequal operands, a branch with nonzero funct3, and any non-branch instruction.
- R6: `insn_misalign` rises when the chosen target has a nonzero low bit that the mode forbids. With `COMPRESSED`=1 only bit 0 counts. With `COMPRESSED`=0 both bits 1:0 count.
- R7: When `advance` is high and the target is aligned, `pc` takes the value reported on `next_pc`. When `advance` is low, `pc` keeps its value.
- R8: When the target is misaligned, `pc` keeps its value even if `advance` is high.
- R9: `load_misalign` rises only for a word load (opcode 0x03, funct3 2) whose `data_addr_lo` is not 0. Loads with any other funct3 never raise it.
- R10: `pc` always obeys the alignment rule of the selected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| advance | input | 1 | Strobe that lets the PC move to the chosen target |
| insn | input | 32 | Current instruction word |
| opnd_a | input | XLEN | First source operand value |
| opnd_b | input | XLEN | Second source operand value |
| data_addr_lo | input | 2 | Low two bits of the computed data address |
| pc | output | XLEN | Registered program counter |
| next_pc | output | XLEN | Registered chosen target for the sampled instruction |
| fmt_r | output | 1 | Register-register format |
| fmt_i | output | 1 | Immediate format |
| fmt_s | output | 1 | Store format |
| fmt_b | output | 1 | Branch format |
| insn_misalign | output | 1 | Chosen target breaks the PC alignment rule |
| load_misalign | output | 1 | Word load address is not word aligned |

## Verification
The bench samples `next_pc`, the format flags and both misalignment flags one clock after they were driven. It expects `pc` to take its new value on that same edge.

Every driven stimulus is paired with one queued expectation. The expectation holds the results of both the compressed and the non-compressed instance, computed from the PC held by the bench's own model before the edge. The monitor removes the expectation one time unit after the next rising edge and compares it there. Because of that, each comparison lines up with exactly one register stage.

// File: rtl/pc_step_pkg.sv
package pc_step_pkg;
  localparam int INSN_W = 32;
  localparam int OPC_W  = 7;
  localparam int F3_W   = 3;

  localparam logic [OPC_W-1:0] OPC_REG    = 7'h33;
  localparam logic [OPC_W-1:0] OPC_IMM    = 7'h13;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'h03;
  localparam logic [OPC_W-1:0] OPC_JREG   = 7'h67;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'h23;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'h63;

  localparam logic [F3_W-1:0] F3_EQ   = 3'd0;
  localparam logic [F3_W-1:0] F3_WORD = 3'd2;

  typedef struct packed {
    logic r;
    logic i;
    logic s;
    logic b;
  } fmt_t;
endpackage

// File: rtl/insn_format_decode.sv
module insn_format_decode
  import pc_step_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [F3_W-1:0]  funct3,
  output fmt_t             fmt,
  output logic             is_beq,
  output logic             is_word_load
);
  always_comb begin
    fmt = '0;
    unique case (opcode)
      OPC_REG:                     fmt.r = 1'b1;
      OPC_IMM, OPC_LOAD, OPC_JREG: fmt.i = 1'b1;
      OPC_STORE:                   fmt.s = 1'b1;
      OPC_BRANCH:                  fmt.b = 1'b1;
      default:                     fmt   = '0;
    endcase
  end

  assign is_beq       = (opcode == OPC_BRANCH) && (funct3 == F3_EQ);
  assign is_word_load = (opcode == OPC_LOAD)   && (funct3 == F3_WORD);
endmodule

// File: rtl/branch_target_calc.sv
module branch_target_calc #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc_cur,
  input  logic [6:0]      hi_field,
  input  logic [4:0]      lo_field,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  input  logic            is_beq,
  output logic [XLEN-1:0] target
);
  localparam int IMM_W = 13;
  localparam int EXT_W = XLEN - IMM_W;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [IMM_W-1:0] imm_raw;
  logic [XLEN-1:0]  imm_ext;
  logic             taken;

  // offset bits: 12 | 11 | 10:5 | 4:1 | 0
  assign imm_raw = {hi_field[6], lo_field[0], hi_field[5:0], lo_field[4:1], 1'b0};
  assign imm_ext = {{EXT_W{imm_raw[IMM_W-1]}}, imm_raw};
  assign taken   = is_beq && (opnd_a == opnd_b);
  assign target  = taken ? (pc_cur + imm_ext) : (pc_cur + STEP);
endmodule

// File: rtl/align_guard.sv
module align_guard #(
  parameter int XLEN       = 32,
  parameter bit COMPRESSED = 1'b0
) (
  input  logic [XLEN-1:0] target,
  input  logic [1:0]      data_addr_lo,
  input  logic            is_word_load,
  output logic            tgt_bad,
  output logic            ld_bad
);
  logic unused_hi;
  assign unused_hi = ^target[XLEN-1:2];

  generate
    if (COMPRESSED) begin : g_half
      logic unused_b1;
      assign unused_b1 = target[1] & unused_hi;
      assign tgt_bad   = target[0];
    end else begin : g_word
      assign tgt_bad = |target[1:0];
    end
  endgenerate

  assign ld_bad = is_word_load && (data_addr_lo != 2'b00);
endmodule

// File: rtl/pc_step_unit.sv
module pc_step_unit
  import pc_step_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter bit              COMPRESSED = 1'b0,
  parameter logic [XLEN-1:0] RESET_VEC  = XLEN'(32'h0000_1000)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            advance,
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  input  logic [1:0]      data_addr_lo,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] next_pc,
  output logic            fmt_r,
  output logic            fmt_i,
  output logic            fmt_s,
  output logic            fmt_b,
  output logic            insn_misalign,
  output logic            load_misalign
);
  fmt_t            fmt_c;
  logic            is_beq_c;
  logic            is_wload_c;
  logic [XLEN-1:0] target_c;
  logic            tgt_bad_c;
  logic            ld_bad_c;
  logic            unused_rs;

  assign unused_rs = ^insn[24:15];

  insn_format_decode u_dec (
    .opcode       (insn[6:0]),
    .funct3       (insn[14:12]),
    .fmt          (fmt_c),
    .is_beq       (is_beq_c),
    .is_word_load (is_wload_c)
  );

  branch_target_calc #(.XLEN(XLEN)) u_tgt (
    .pc_cur   (pc),
    .hi_field (insn[31:25]),
    .lo_field (insn[11:7]),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .is_beq   (is_beq_c),
    .target   (target_c)
  );

  align_guard #(.XLEN(XLEN), .COMPRESSED(COMPRESSED)) u_algn (
    .target       (target_c),
    .data_addr_lo (data_addr_lo),
    .is_word_load (is_wload_c),
    .tgt_bad      (tgt_bad_c),
    .ld_bad       (ld_bad_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc            <= RESET_VEC;
      next_pc       <= RESET_VEC;
      fmt_r         <= 1'b0;
      fmt_i         <= 1'b0;
      fmt_s         <= 1'b0;
      fmt_b         <= 1'b0;
      insn_misalign <= 1'b0;
      load_misalign <= 1'b0;
    end else begin
      if (advance && !tgt_bad_c) pc <= target_c;
      next_pc       <= target_c;
      fmt_r         <= fmt_c.r;
      fmt_i         <= fmt_c.i;
      fmt_s         <= fmt_c.s;
      fmt_b         <= fmt_c.b;
      insn_misalign <= tgt_bad_c;
      load_misalign <= ld_bad_c;
    end
  end
endmodule

// File: rtl/pc_step_unit_chk.sv
module pc_step_unit_chk #(
  parameter int XLEN       = 32,
  parameter bit COMPRESSED = 1'b0
) (
  input logic            clk,
  input logic            rst,
  input logic            advance,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] next_pc,
  input logic            fmt_r,
  input logic            fmt_i,
  input logic            fmt_s,
  input logic            fmt_b,
  input logic            insn_misalign,
  input logic            load_misalign
);
  // R3
  fmt_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fmt_r, fmt_i, fmt_s, fmt_b}));

  // R10
  pc_align_chk: assert property (@(posedge clk) disable iff (rst)
    (COMPRESSED != 0) ? (pc[0] == 1'b0) : (pc[1:0] == 2'b00));

  // R8
  misalign_hold_chk: assert property (@(posedge clk) disable iff (rst)
    insn_misalign |-> $stable(pc));

  // R7
  advance_load_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(advance) && !insn_misalign) |-> (pc == next_pc));

  // R5
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !fmt_b) |-> (next_pc == $past(pc) + XLEN'(4)));

  // R9
  load_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    load_misalign |-> fmt_i);
endmodule

bind pc_step_unit pc_step_unit_chk #(.XLEN(XLEN), .COMPRESSED(COMPRESSED)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .advance       (advance),
  .pc            (pc),
  .next_pc       (next_pc),
  .fmt_r         (fmt_r),
  .fmt_i         (fmt_i),
  .fmt_s         (fmt_s),
  .fmt_b         (fmt_b),
  .insn_misalign (insn_misalign),
  .load_misalign (load_misalign)
);

// File: tb/pc_step_unit_bench.sv
`timescale 1ns/1ps
module pc_step_unit_bench;
  localparam int XLEN = 32;
  localparam logic [31:0] RV = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic advance = 1'b0;
  logic [31:0] insn = 32'h0;
  logic [31:0] opa = 32'h0, opb = 32'h0;
  logic [1:0]  dlo = 2'b00;

  logic [31:0] pc0, npc0, pc1, npc1;
  logic fr0, fi0, fs0, fb0, im0, lm0;
  logic fr1, fi1, fs1, fb1, im1, lm1;

  always #2.5 clk = ~clk;

  pc_step_unit #(.XLEN(XLEN), .COMPRESSED(1'b0), .RESET_VEC(RV)) u_pc_step_unit (
    .clk(clk), .rst(rst), .advance(advance), .insn(insn), .opnd_a(opa), .opnd_b(opb),
    .data_addr_lo(dlo), .pc(pc0), .next_pc(npc0), .fmt_r(fr0), .fmt_i(fi0), .fmt_s(fs0),
    .fmt_b(fb0), .insn_misalign(im0), .load_misalign(lm0));

  pc_step_unit #(.XLEN(XLEN), .COMPRESSED(1'b1), .RESET_VEC(RV)) u_pc_step_unit_c (
    .clk(clk), .rst(rst), .advance(advance), .insn(insn), .opnd_a(opa), .opnd_b(opb),
    .data_addr_lo(dlo), .pc(pc1), .next_pc(npc1), .fmt_r(fr1), .fmt_i(fi1), .fmt_s(fs1),
    .fmt_b(fb1), .insn_misalign(im1), .load_misalign(lm1));

  typedef struct {
    logic [31:0] pc0, npc0, pc1, npc1;
    logic [3:0]  fmt;
    logic        im0, im1, lm;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  logic [31:0] mpc0 = RV, mpc1 = RV;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] beq(input logic [12:0] off, input logic [2:0] f3);
    return {off[12], off[10:5], 5'd2, 5'd1, f3, off[4:1], off[11], 7'h63};
  endfunction

  // step: drive one instruction and queue its expected results
  task automatic step(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                      input logic [1:0] lo, input logic adv, input string tag);
    exp_t e;
    logic [6:0] op;
    logic [2:0] f3;
    logic [31:0] off;
    logic tk;
    @(negedge clk);
    insn = w; opa = a; opb = b; dlo = lo; advance = adv;
    op = w[6:0]; f3 = w[14:12];
    off = {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
    tk = (op == 7'h63) && (f3 == 3'd0) && (a == b);
    e.fmt = {op == 7'h33, op == 7'h13 || op == 7'h03 || op == 7'h67, op == 7'h23, op == 7'h63};
    e.lm  = (op == 7'h03) && (f3 == 3'd2) && (lo != 2'b00);
    e.npc0 = tk ? mpc0 + off : mpc0 + 32'd4;
    e.npc1 = tk ? mpc1 + off : mpc1 + 32'd4;
    e.im0 = |e.npc0[1:0];
    e.im1 = e.npc1[0];
    e.pc0 = (adv && !e.im0) ? e.npc0 : mpc0;
    e.pc1 = (adv && !e.im1) ? e.npc1 : mpc1;
    mpc0 = e.pc0; mpc1 = e.pc1;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare one edge after each driven stimulus
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(npc0 === e.npc0, {e.tag, " next_pc nc"}, npc0, e.npc0);
        chk(npc1 === e.npc1, {e.tag, " next_pc c"}, npc1, e.npc1);
        chk(pc0 === e.pc0, {e.tag, " pc nc"}, pc0, e.pc0);
        chk(pc1 === e.pc1, {e.tag, " pc c"}, pc1, e.pc1);
        chk({fr0, fi0, fs0, fb0} === e.fmt && {fr1, fi1, fs1, fb1} === e.fmt,
            {e.tag, " R2 R3 fmt"}, {28'd0, fr0, fi0, fs0, fb0}, {28'd0, e.fmt});
        chk(im0 === e.im0 && im1 === e.im1, {e.tag, " R6 insn_misalign"},
            {30'd0, im0, im1}, {30'd0, e.im0, e.im1});
        chk(lm0 === e.lm && lm1 === e.lm, {e.tag, " R9 load_misalign"},
            {30'd0, lm0, lm1}, {31'd0, e.lm});
      end
    end
  end

  task automatic reset_check(input string tag);
    @(negedge clk);
    rst = 1'b1; advance = 1'b1;
    repeat (3) @(negedge clk);
    mpc0 = RV; mpc1 = RV;
    // R1
    chk(pc0 === RV && pc1 === RV, {tag, " R1 pc"}, pc0, RV);
    chk(npc0 === RV && npc1 === RV, {tag, " R1 next_pc"}, npc0, RV);
    chk({fr0, fi0, fs0, fb0, im0, lm0, fr1, fi1, fs1, fb1, im1, lm1} === 12'd0,
        {tag, " R1 flags"}, {20'd0, fr0, fi0, fs0, fb0, im0, lm0, fr1, fi1, fs1, fb1, im1, lm1}, 32'd0);
    rst = 1'b0; advance = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    reset_check("first");
    step(32'h0020_81B3, 1, 2, 0, 1, "R2 reg-reg R5");
    step(32'h0050_8093, 0, 0, 0, 1, "R2 imm");
    step(32'h0000_8067, 0, 0, 0, 1, "R2 jump-reg");
    step(32'h0000_A083, 0, 0, 2'b00, 1, "R9 aligned word load");
    step(32'h0000_A083, 0, 0, 2'b10, 1, "R9 misaligned word load");
    step(32'h0000_8083, 0, 0, 2'b01, 1, "R9 byte load ignored");
    step(32'h0020_A023, 0, 0, 2'b11, 1, "R2 store");
    step(32'h0000_0037, 0, 0, 0, 1, "R2 unknown opcode");
    step(beq(13'd16, 3'd0), 32'h55, 32'h55, 0, 1, "R4 taken forward");
    step(beq(13'd16, 3'd0), 32'h55, 32'h56, 0, 1, "R5 unequal");
    step(beq(13'd16, 3'd1), 32'h7, 32'h7, 0, 1, "R5 other funct3");
    step(beq(-13'sd8, 3'd0), 32'h9, 32'h9, 0, 1, "R4 taken backward");
    step(beq(13'd6, 3'd0), 32'h1, 32'h1, 0, 1, "R6 R8 half-aligned target");
    step(beq(-13'sd2048, 3'd0), 32'h3, 32'h3, 0, 1, "R4 large backward");
    step(beq(13'd12, 3'd0), 32'h3, 32'h3, 0, 0, "R7 no advance");
    step(32'h0020_81B3, 0, 0, 0, 0, "R7 hold sequential");
    step(beq(13'd2, 3'd0), 32'h0, 32'h0, 0, 1, "R6 R10 odd-half target");
    step(32'h0020_81B3, 0, 0, 0, 1, "R5 after half step");
    @(negedge clk);
    reset_check("second");
    step(beq(13'd4094, 3'd0), 32'hA, 32'hA, 0, 1, "R4 max forward");
    step(32'h0000_A083, 0, 0, 2'b01, 1, "R9 low bit");
    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule